// File: doc/BRIEF.md
# Product Shift Mode Unit

This block keeps a 3-bit shift-mode field and uses it to scale a 32-bit signed product. The scaled value goes on to an arithmetic unit or to a store path. A mode code can pick one of three things: a left shift by one with the low bit filled with zero, a straight pass-through, or an arithmetic right shift of one to six places. When the alternate-addressing flag is set, the code that normally means a right shift by four means a left shift by four instead.

The mode register loads on a write strobe and reset clears it. The shift path from the product input to the output is purely combinational. Left shifts drop the bits that leave the top of the word and give no overflow indication.

Top module: `pshift_unit`

## Requirements
- R1: After reset the mode field is 000, so the output equals the product shifted left by one with bit 0 equal to zero.
- R2: Mode 000 gives out = {prod[30:0], 1'b0}. Bit 31 of the product is discarded and no overflow is indicated.
- R3: Mode 001 gives out = prod, unchanged.
- R4: Modes 010, 011, 100, 110 and 111 give an arithmetic right shift of prod by 1, 2, 3, 5 and 6 places. Vacated upper bits take the value of prod[31].
- R5: Mode 101 with alt_mode = 0 gives an arithmetic right shift of prod by 4.
- R6: Mode 101 with alt_mode = 1 gives out = {prod[27:0], 4'b0}. For every other code, alt_mode has no effect.
- R7: A write (mode_we = 1 with mode_wdata) takes effect at the next rising clock edge. While mode_we = 0 the stored mode holds its value.
- R8: The output follows prod combinationally in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | New mode code |
| alt_mode | input | 1 | Alternate addressing flag, changes how code 101 is read |
| prod | input | 32 | Signed product |
| prod_shifted | output | 32 | Shifted product |

## Verification
The assertions check four things on every cycle:
- the register holds its value when there is no write and loads on a write;
- a right shift fills the upper bits with copies of the sign;
- left shifts leave zeros in the low bits;
- alt_mode changes nothing except under code 101.

Exact output values can only be shown by the bench scenarios. These cover every code under both flag values, with positive, negative, zero and extreme products, and also check the reset state and the one-cycle write latency.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned MAX_RSH = 6;
  localparam int unsigned ALT_LSH = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_LSH1 = 3'b000,
    PM_PASS = 3'b001,
    PM_RSH1 = 3'b010,
    PM_RSH2 = 3'b011,
    PM_RSH3 = 3'b100,
    PM_RSH4 = 3'b101,
    PM_RSH5 = 3'b110,
    PM_RSH6 = 3'b111
  } pmode_e;

  typedef struct packed {
    logic       left;
    logic [2:0] amt;
  } shift_ctl_t;
endpackage

// File: rtl/pshift_mode_reg.sv
module pshift_mode_reg
  import pshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output pmode_e            mode_q
);
  pmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we) mode_d = pmode_e'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_LSH1;
    else        mode_q <= mode_d;
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mode_q)) else $error("mode changed without write"); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode_q == $past(wdata))) else $error("mode write lost"); // R7
endmodule

// File: rtl/pshift_decode.sv
module pshift_decode
  import pshift_pkg::*;
(
  input  pmode_e     mode,
  input  logic       alt,
  output shift_ctl_t ctl
);
  always_comb begin
    ctl = '{left: 1'b0, amt: 3'd0};
    unique case (mode)
      PM_LSH1: ctl = '{left: 1'b1, amt: 3'd1};
      PM_PASS: ctl = '{left: 1'b0, amt: 3'd0};
      PM_RSH1: ctl = '{left: 1'b0, amt: 3'd1};
      PM_RSH2: ctl = '{left: 1'b0, amt: 3'd2};
      PM_RSH3: ctl = '{left: 1'b0, amt: 3'd3};
      PM_RSH4: ctl = alt ? '{left: 1'b1, amt: 3'(ALT_LSH)}
                         : '{left: 1'b0, amt: 3'd4};
      PM_RSH5: ctl = '{left: 1'b0, amt: 3'd5};
      PM_RSH6: ctl = '{left: 1'b0, amt: 3'd6};
      default: ctl = '{left: 1'b0, amt: 3'd0};
    endcase
  end

  always_comb begin
    AST_ALT_ONLY_101: assert (mode == PM_RSH4 || alt || !ctl.left || mode == PM_LSH1); // R6
    AST_AMT_RANGE: assert (ctl.amt <= 3'(MAX_RSH)); // R4
  end
endmodule

// File: rtl/pshift_datapath.sv
module pshift_datapath
  import pshift_pkg::*;
(
  input  shift_ctl_t         ctl,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout
);
  localparam int unsigned NOPT = MAX_RSH + 1;
  logic [DATA_W-1:0] rsh [NOPT];
  logic [DATA_W-1:0] lsh [NOPT];

  for (genvar k = 0; k < NOPT; k++) begin : g_sh
    assign rsh[k] = $signed(din) >>> k;
    assign lsh[k] = din << k;
  end

  always_comb begin
    dout = din;
    for (int i = 0; i < NOPT; i++) begin
      if (ctl.amt == 3'(i)) dout = ctl.left ? lsh[i] : rsh[i];
    end
  end

  always_comb begin
    if (!ctl.left && ctl.amt != 3'd0)
      AST_SIGN_FILL: assert (dout[DATA_W-1] == din[DATA_W-1]); // R4
    if (ctl.left && ctl.amt != 3'd0)
      AST_ZERO_LOW: assert (dout[0] == 1'b0); // R2
  end
endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [2:0]  mode_wdata,
  input  logic        alt_mode,
  input  logic [31:0] prod,
  output logic [31:0] prod_shifted
);
  pmode_e     mode_q;
  shift_ctl_t ctl;

  pshift_mode_reg u_mreg (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata), .mode_q(mode_q)
  );
  pshift_decode u_dec (.mode(mode_q), .alt(alt_mode), .ctl(ctl));
  pshift_datapath u_dp (.ctl(ctl), .din(prod), .dout(prod_shifted));

  AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_PASS) |-> (prod_shifted == prod)) else $error("pass mode altered data"); // R3
endmodule

// File: tb/tb_pshift_unit.sv
module tb_pshift_unit;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 0, rst_n = 0, mode_we = 0, alt_mode = 0;
  logic [2:0] mode_wdata = '0;
  logic [31:0] prod = '0;
  logic [31:0] prod_shifted;
  int checks = 0, errors = 0;

  pshift_unit dut (.*);
  always #(CLK_PERIOD/2) clk = ~clk;

  localparam int NP = 6;
  localparam logic [31:0] PATS [NP] = '{32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF,
                                         32'h7FFF_FFFF, 32'h8000_0000, 32'hC0DE_F00D};

  function automatic logic [31:0] model(input logic [2:0] m, input logic a, input logic [31:0] p);
    case (m)
      3'b000: return {p[30:0], 1'b0};
      3'b001: return p;
      3'b101: return a ? {p[27:0], 4'b0} : 32'($signed(p) >>> 4);
      default: return 32'($signed(p) >>> (m - 1));
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (prod_shifted !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, prod_shifted, exp);
    end
  endtask

  task automatic wr(input logic [2:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++; checks++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prod = 32'h8000_0001;
    #1 check("R1 reset-inert", 32'h0000_0002);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'h0000_0002);
    for (int m = 0; m < 8; m++) begin
      wr(3'(m));
      for (int a = 0; a < 2; a++) begin
        alt_mode = a[0];
        for (int i = 0; i < NP; i++) begin
          prod = PATS[i]; #1;
          if (m == 0) check("R2", model(3'(m), a[0], prod));
          else if (m == 1) check("R3", model(3'(m), a[0], prod));
          else if (m == 5 && a == 0) check("R5", model(3'(m), a[0], prod));
          else if (m == 5) check("R6", model(3'(m), a[0], prod));
          else check(a ? "R6 alt-ignored" : "R4", model(3'(m), a[0], prod));
        end
      end
    end
    // R8 combinational follow
    wr(3'b111); alt_mode = 0;
    prod = 32'h8000_0000; #1 check("R8", 32'hFE00_0000);
    prod = 32'h4000_0000; #1 check("R8", 32'h0100_0000);
    // R7 latency: write lands only at the next edge
    @(negedge clk); mode_we = 1; mode_wdata = 3'b001; prod = 32'h0000_0040;
    #1 check("R7 before edge", 32'h0000_0001);
    @(negedge clk); mode_we = 0; #1 check("R7 after edge", 32'h0000_0040);
    mode_wdata = 3'b000; repeat (3) @(negedge clk);
    check("R7 hold", 32'h0000_0040);
    // reset returns to 000
    rst_n = 0; #1 check("R1 async", 32'h0000_0080);
    @(negedge clk); rst_n = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule